// File: doc/BRIEF.md
# Load Address Check Table

This block is a small, fully associative table that guards loads a compiler has moved above stores that might alias them. When such an early ("advanced") load issues, its doubleword address is stored in the table under the tag of the register it writes. Every store looks up its own doubleword address across the whole table at once, and any entry with the same doubleword is invalidated.

At the load's original position a check operation names the destination register. The check succeeds if the table still holds a valid entry for that register, and a successful check frees that entry. If the entry was invalidated by a store, pushed out by replacement, or never written, the check reports that fixup code must run, and the table is left as it was.

The table has three ports: insert, store snoop and check. Any or all of them may be active in the same cycle. A check response appears one clock after its request.

Top module: `ld_check_table`

## Requirements
- R1: After reset every entry is invalid, so any check reports fixup. While reset is held, `chk_resp_valid`, `chk_ok` and `chk_fixup` are 0.
- R2: A check in cycle N gives a response in cycle N+1: `chk_resp_valid` is 1 exactly in the cycle after `chk_valid` was 1. `chk_ok` is 1 if a valid entry with tag `chk_tag` existed in cycle N.
- R3: A check for a tag with no valid entry raises `chk_fixup` and changes no entry. A repeated check of the same tag again reports fixup, and checks of other present tags still succeed.
- R4: A successful check invalidates the entry it hit, so a second check of the same tag with no insert in between reports fixup.
- R5: A store invalidates every valid entry whose address bits [31:3] equal the store's bits [31:3]. Bits [2:0] are ignored. Entries in other doublewords stay valid.
- R6: An insert whose tag matches a valid entry overwrites that entry's address, and no second entry is created. A store to the old address then no longer affects that tag.
- R7: An insert with a new tag takes the lowest-numbered invalid entry. When all 8 entries are valid, it replaces the entry named by a round-robin pointer. The pointer starts at entry 0 after reset and advances by one, wrapping from 7 to 0, only on such a replacement. Entries fill in insert order, so entry i is the (i+1)-th distinct insert after reset.
- R8: When an insert and a store to the same doubleword occur in the same cycle, the insert is applied after the store, and the new entry is valid.
- R9: A check uses the table contents from before the same cycle's store and insert. A check that coincides with an insert of its own tag reports fixup if the tag was absent, and the inserted entry is present afterwards. A check that coincides with a store to the entry's doubleword still succeeds.
- R10: When `chk_resp_valid` is 1, exactly one of `chk_ok` and `chk_fixup` is 1. When it is 0, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_valid | input | 1 | Advanced-load insert request |
| ins_tag | input | 6 | Destination register tag of the advanced load |
| ins_addr | input | 32 | Address of the advanced load |
| st_valid | input | 1 | Store snoop request |
| st_addr | input | 32 | Store address |
| chk_valid | input | 1 | Check request |
| chk_tag | input | 6 | Register tag to check |
| chk_resp_valid | output | 1 | Check response present, one cycle after the request |
| chk_ok | output | 1 | Entry was still valid; speculation succeeded |
| chk_fixup | output | 1 | Entry invalidated or missing; fixup needed |

## Verification
The assertions take for granted that the inputs are known (not X) whenever their valid strobe is high, and that all table updates come only through the three ports. They also rely on the invariant that no two valid entries ever share a tag.

The stimulus keeps within these assumptions by driving every data field with a defined value in each cycle and changing inputs only at the falling edge. A long pseudo-random sweep draws from 12 register tags and 6 doublewords with random byte offsets. This produces frequent replacements, tag overwrites, store kills and same-cycle collisions, and each response is compared against an arithmetic model of the rules.

// File: rtl/lsat_pkg.sv
package lsat_pkg;
    localparam int unsigned LSAT_ENTRIES = 8;
    localparam int unsigned LSAT_TAG_W   = 6;
    localparam int unsigned LSAT_ADDR_W  = 32;
    localparam int unsigned LSAT_OFF_W   = 3;   // doubleword granularity
endpackage

// File: rtl/lsat_match.sv
// Parallel equality compare of one probe value against every entry field.
module lsat_match #(
    parameter int unsigned N = 8,
    parameter int unsigned W = 6
) (
    input  logic [N-1:0][W-1:0] field,
    input  logic [W-1:0]        probe,
    output logic [N-1:0]        hit
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = (field[g] == probe);
    end
endmodule

// File: rtl/lsat_victim.sv
// Slot choice for an insert: same-tag entry, else lowest free, else round-robin.
module lsat_victim #(
    parameter int unsigned N     = 8,
    parameter int unsigned IDX_W = 3
) (
    input  logic [N-1:0]     live,
    input  logic [N-1:0]     same_tag,
    input  logic [IDX_W-1:0] rr_ptr,
    output logic [IDX_W-1:0] slot,
    output logic             evict
);
    logic [IDX_W-1:0] tag_slot;
    logic [IDX_W-1:0] free_slot;
    logic             tag_found;
    logic             free_found;

    always_comb begin
        tag_slot   = '0;
        free_slot  = '0;
        tag_found  = 1'b0;
        free_found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (live[i] && same_tag[i]) begin
                tag_slot  = IDX_W'(i);
                tag_found = 1'b1;
            end
            if (!live[i]) begin
                free_slot  = IDX_W'(i);
                free_found = 1'b1;
            end
        end
        if (tag_found) begin
            slot  = tag_slot;
            evict = 1'b0;
        end else if (free_found) begin
            slot  = free_slot;
            evict = 1'b0;
        end else begin
            slot  = rr_ptr;
            evict = 1'b1;
        end
    end
endmodule

// File: rtl/ld_check_table.sv
module ld_check_table
    import lsat_pkg::*;
#(
    parameter int unsigned ENTRIES = LSAT_ENTRIES,
    parameter int unsigned TAG_W   = LSAT_TAG_W,
    parameter int unsigned ADDR_W  = LSAT_ADDR_W,
    parameter int unsigned OFF_W   = LSAT_OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [TAG_W-1:0]  ins_tag,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              chk_valid,
    input  logic [TAG_W-1:0]  chk_tag,
    output logic              chk_resp_valid,
    output logic              chk_ok,
    output logic              chk_fixup
);
    localparam int unsigned KEY_W = ADDR_W - OFF_W;
    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][TAG_W-1:0]  tag;
        logic [ENTRIES-1:0][KEY_W-1:0]  key;
        logic [IDX_W-1:0]               rr;
        logic                           rsp_v;
        logic                           rsp_ok;
        logic                           rsp_fix;
    } state_t;

    state_t st_q, st_d;

    logic [KEY_W-1:0]   st_key, ins_key;
    logic [ENTRIES-1:0] chk_tag_hit, st_key_hit, ins_tag_hit;
    logic [ENTRIES-1:0] live_after_chk, live_after_st;
    logic [IDX_W-1:0]   ins_slot;
    logic               ins_evict;
    logic               chk_found;

    // signals exposed to the bound checker
    logic [ENTRIES-1:0]            valid_q;
    logic [ENTRIES-1:0][TAG_W-1:0] tag_q;
    logic [ENTRIES-1:0][KEY_W-1:0] key_q;

    assign st_key  = st_addr[ADDR_W-1:OFF_W];
    assign ins_key = ins_addr[ADDR_W-1:OFF_W];

    lsat_match #(.N(ENTRIES), .W(TAG_W)) u_chk_match (
        .field(st_q.tag), .probe(chk_tag), .hit(chk_tag_hit)
    );
    lsat_match #(.N(ENTRIES), .W(KEY_W)) u_st_match (
        .field(st_q.key), .probe(st_key), .hit(st_key_hit)
    );
    lsat_match #(.N(ENTRIES), .W(TAG_W)) u_ins_match (
        .field(st_q.tag), .probe(ins_tag), .hit(ins_tag_hit)
    );

    // check lookup on the registered contents
    assign chk_found = |(chk_tag_hit & st_q.valid);

    // update order within a cycle: check clear, store kill, then insert
    always_comb begin
        live_after_chk = st_q.valid;
        if (chk_valid && chk_found) begin
            live_after_chk = st_q.valid & ~chk_tag_hit;
        end
        live_after_st = live_after_chk;
        if (st_valid) begin
            live_after_st = live_after_chk & ~st_key_hit;
        end
    end

    lsat_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .live    (live_after_st),
        .same_tag(ins_tag_hit),
        .rr_ptr  (st_q.rr),
        .slot    (ins_slot),
        .evict   (ins_evict)
    );

    always_comb begin
        st_d         = st_q;
        st_d.valid   = live_after_st;
        st_d.rsp_v   = chk_valid;
        st_d.rsp_ok  = chk_valid && chk_found;
        st_d.rsp_fix = chk_valid && !chk_found;
        if (ins_valid) begin
            st_d.valid[ins_slot] = 1'b1;
            st_d.tag[ins_slot]   = ins_tag;
            st_d.key[ins_slot]   = ins_key;
            if (ins_evict) begin
                st_d.rr = (st_q.rr == IDX_W'(ENTRIES - 1)) ? '0 : st_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chk_resp_valid = st_q.rsp_v;
    assign chk_ok         = st_q.rsp_ok;
    assign chk_fixup      = st_q.rsp_fix;

    assign valid_q = st_q.valid;
    assign tag_q   = st_q.tag;
    assign key_q   = st_q.key;
endmodule

// File: rtl/lsat_checker.sv
module lsat_checker #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned TAG_W   = 6,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned OFF_W   = 3
) (
    input logic                                    clk,
    input logic                                    rst_n,
    input logic                                    ins_valid,
    input logic [ADDR_W-1:0]                       ins_addr,
    input logic                                    st_valid,
    input logic [ADDR_W-1:0]                       st_addr,
    input logic                                    chk_valid,
    input logic                                    chk_resp_valid,
    input logic                                    chk_ok,
    input logic                                    chk_fixup,
    input logic [ENTRIES-1:0]                      valid_q,
    input logic [ENTRIES-1:0][TAG_W-1:0]           tag_q,
    input logic [ENTRIES-1:0][ADDR_W-OFF_W-1:0]    key_q
);
    localparam int unsigned KEY_W = ADDR_W - OFF_W;

    logic [KEY_W-1:0]   st_key, ins_key;
    logic [ENTRIES-1:0] dup_tag;

    assign st_key  = st_addr[ADDR_W-1:OFF_W];
    assign ins_key = ins_addr[ADDR_W-1:OFF_W];

    always_comb begin
        dup_tag = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            for (int j = 0; j < ENTRIES; j++) begin
                if (i != j && valid_q[i] && valid_q[j] && tag_q[i] == tag_q[j]) begin
                    dup_tag[i] = 1'b1;
                end
            end
        end
    end

    // R2: response exactly one cycle after a request
    a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> chk_resp_valid);
    a_r2_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !chk_resp_valid);

    // R10: response encoding
    a_r10_one_hot_resp: assert property (@(posedge clk) disable iff (!rst_n)
        chk_resp_valid |-> $countones({chk_ok, chk_fixup}) == 1);
    a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_resp_valid |-> !chk_ok && !chk_fixup);

    // R6: a tag lives in at most one valid entry
    a_r6_unique_tag: assert property (@(posedge clk) disable iff (!rst_n)
        dup_tag == '0);

    // R5: after a store no valid entry keeps its doubleword, unless R8 re-inserted it
    for (genvar g = 0; g < ENTRIES; g++) begin : g_kill
        a_r5_store_kills: assert property (@(posedge clk) disable iff (!rst_n)
            (st_valid && !(ins_valid && ins_key == st_key))
            |=> !(valid_q[g] && key_q[g] == $past(st_key)));
    end
endmodule

bind ld_check_table lsat_checker #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)
) u_lsat_checker (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_addr(ins_addr),
    .st_valid(st_valid), .st_addr(st_addr),
    .chk_valid(chk_valid),
    .chk_resp_valid(chk_resp_valid), .chk_ok(chk_ok), .chk_fixup(chk_fixup),
    .valid_q(valid_q), .tag_q(tag_q), .key_q(key_q)
);

// File: tb/tb_ld_check_table.sv
`timescale 1ns/1ps
module tb_ld_check_table;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0;
    logic [5:0]  ins_tag = '0;
    logic [31:0] ins_addr = '0;
    logic        st_valid = 1'b0;
    logic [31:0] st_addr = '0;
    logic        chk_valid = 1'b0;
    logic [5:0]  chk_tag = '0;
    logic        chk_resp_valid, chk_ok, chk_fixup;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model
    bit          mv [N];
    logic [5:0]  mt [N];
    logic [28:0] mk [N];
    int          mrr;

    always #5 clk = ~clk;

    ld_check_table dut (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_tag(ins_tag), .ins_addr(ins_addr),
        .st_valid(st_valid), .st_addr(st_addr),
        .chk_valid(chk_valid), .chk_tag(chk_tag),
        .chk_resp_valid(chk_resp_valid), .chk_ok(chk_ok), .chk_fixup(chk_fixup)
    );

    task automatic report(input bit pass, input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (!pass) begin
            fails++;
            $display("FAIL %s: {resp_valid,ok,fixup} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ins_valid = 0; st_valid = 0; chk_valid = 0;
        for (int i = 0; i < N; i++) begin
            mv[i] = 0; mt[i] = '0; mk[i] = '0;
        end
        mrr = 0;
        @(negedge clk);
        // R1: outputs quiet while reset held
        report({chk_resp_valid, chk_ok, chk_fixup} == 3'b000, "R1",
               {chk_resp_valid, chk_ok, chk_fixup}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one cycle; want: 1 expect ok, 0 expect fixup, -1 model only
    task automatic step(input bit iv, input logic [5:0] it, input logic [31:0] ia,
                        input bit sv, input logic [31:0] sa,
                        input bit cv, input logic [5:0] ct,
                        input int want, input string req);
        bit found;
        int fidx, slot;
        bit tslot_ok, free_ok;
        logic [2:0] exp, act;
        ins_valid = iv; ins_tag = it; ins_addr = ia;
        st_valid = sv;  st_addr = sa;
        chk_valid = cv; chk_tag = ct;
        found = 0; fidx = 0;
        for (int i = 0; i < N; i++) if (mv[i] && mt[i] == ct) begin found = 1; fidx = i; end
        exp = {cv, cv && found, cv && !found};
        if (cv && found) mv[fidx] = 0;
        if (sv) for (int i = 0; i < N; i++) if (mv[i] && mk[i] == sa[31:3]) mv[i] = 0;
        if (iv) begin
            tslot_ok = 0; free_ok = 0; slot = 0;
            for (int i = N - 1; i >= 0; i--) if (mv[i] && mt[i] == it) begin tslot_ok = 1; slot = i; end
            if (!tslot_ok) begin
                for (int i = N - 1; i >= 0; i--) if (!mv[i]) begin free_ok = 1; slot = i; end
                if (!free_ok) begin slot = mrr; mrr = (mrr + 1) % N; end
            end
            mv[slot] = 1; mt[slot] = it; mk[slot] = ia[31:3];
        end
        @(negedge clk);
        act = {chk_resp_valid, chk_ok, chk_fixup};
        report(act == exp, req, act, exp);
        if (want >= 0) begin
            exp = (want == 1) ? 3'b110 : 3'b101;
            report(act == exp, req, act, exp);
        end
    endtask

    task automatic ins(input logic [5:0] t, input logic [31:0] a, input string req);
        step(1, t, a, 0, 0, 0, 0, -1, req);
    endtask
    task automatic st(input logic [31:0] a, input string req);
        step(0, 0, 0, 1, a, 0, 0, -1, req);
    endtask
    task automatic chk(input logic [5:0] t, input int want, input string req);
        step(0, 0, 0, 0, 0, 1, t, want, req);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        do_reset();
        // R1: empty table reports fixup
        chk(6'd0, 0, "R1");
        chk(6'd63, 0, "R1");

        // R2 / R4: insert, check ok, second check fixup
        ins(6'd5, 32'h0000_1000, "R2");
        chk(6'd5, 1, "R2");
        chk(6'd5, 0, "R4");

        // R3: absent tag leaves others intact
        ins(6'd7, 32'h0000_2000, "R3");
        chk(6'd8, 0, "R3");
        chk(6'd8, 0, "R3");
        chk(6'd7, 1, "R3");

        // R5: doubleword match, offsets ignored, multiple kills
        ins(6'd1, 32'h0000_3000, "R5");
        ins(6'd2, 32'h0000_3004, "R5");
        ins(6'd3, 32'h0000_3008, "R5");
        st(32'h0000_3007, "R5");
        chk(6'd1, 0, "R5");
        chk(6'd2, 0, "R5");
        chk(6'd3, 1, "R5");

        // R6: overwrite on same tag
        ins(6'd9, 32'h0000_4000, "R6");
        ins(6'd9, 32'h0000_5000, "R6");
        st(32'h0000_4000, "R6");
        chk(6'd9, 1, "R6");
        chk(6'd9, 0, "R6");

        // R8: same-cycle insert and store to same doubleword
        step(1, 6'd12, 32'h0000_6000, 1, 32'h0000_6004, 0, 0, -1, "R8");
        chk(6'd12, 1, "R8");

        // R9: check sees pre-update state
        step(1, 6'd13, 32'h0000_7000, 0, 0, 1, 6'd13, 0, "R9");
        chk(6'd13, 1, "R9");
        ins(6'd14, 32'h0000_8000, "R9");
        step(0, 0, 0, 1, 32'h0000_8000, 1, 6'd14, 1, "R9");
        ins(6'd15, 32'h0000_9000, "R9");
        step(1, 6'd15, 32'h0000_A000, 0, 0, 1, 6'd15, 1, "R9");
        chk(6'd15, 1, "R9");

        // R7: fill and round-robin replacement
        do_reset();
        for (int i = 1; i <= 8; i++) ins(6'(i), 32'(i) << 8, "R7");
        ins(6'd20, 32'h0001_0000, "R7");  // evicts entry 0 (tag 1)
        chk(6'd1, 0, "R7");
        chk(6'd20, 1, "R7");              // frees entry 0
        ins(6'd21, 32'h0001_1000, "R7");  // lowest free: entry 0
        ins(6'd22, 32'h0001_2000, "R7");  // evicts entry 1 (tag 2)
        chk(6'd2, 0, "R7");
        chk(6'd3, 1, "R7");
        chk(6'd21, 1, "R7");
        for (int i = 4; i <= 8; i++) chk(6'(i), 1, "R7");

        // sweep: all requirements against the model (R2..R10)
        do_reset();
        lf = 32'h1ACE_B00C;
        for (int n = 0; n < 6000; n++) begin
            logic [31:0] r;
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            r = lf;
            step(r[0], 6'(r[4:1] % 12), {26'h40, 3'(r[7:5] % 6), r[10:8]},
                 r[11] & r[12], {26'h40, 3'(r[15:13] % 6), r[18:16]},
                 r[19], 6'(r[23:20] % 12), -1, "R10");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule